// File: doc/BRIEF.md
# Table-Driven Route Index Rewriter

This block is the routing stage that sits on one input of a network switch that uses table-driven routing. Every packet opens with a head flit whose routing index selects an entry in a small local table. The entry names the output port the packet must take and the index the next switch will use. The stage swaps the new index into the head flit, steers the flit to the chosen port and keeps that port for the rest of the packet. The path stays open until the tail flit has passed.

The table is loaded through a simple write port that takes an address, an output port, a next index and an entry-valid bit. A head flit that hits an entry marked invalid goes to a fixed error port, together with the rest of its packet, and a sticky error flag is raised. A body or tail flit that arrives while no path is open is also sent to the error port and raises the flag.

Every flit passes through exactly one register stage, so flits can arrive on back-to-back cycles with no gaps. The table lookup for a head flit happens inside that same stage.

Top module: `route_idx_stage`

## Requirements
- R1: After reset, out_valid and err_flag are 0 and every table entry is invalid, so a head flit sent before any configuration leaves on port ERR_PORT (default 7).
- R2: A head flit presented at a clock edge leaves one cycle later with out_head set. out_port is the port stored in the entry selected by in_data[IDX_LSB +: IDX_W] (default bits 5:0), and that index field is replaced by the stored next index. All other data bits are unchanged.
- R3: Body and tail flits leave one cycle after they arrive, with their data unchanged and out_port equal to the port chosen for the head flit of their packet.
- R4: out_valid in each cycle equals in_valid one cycle earlier, so flits arriving on consecutive cycles leave on consecutive cycles.
- R5: A tail flit closes the path. A later body or tail flit that arrives with no head flit before it leaves on ERR_PORT and sets err_flag.
- R6: A head flit whose entry is invalid leaves on ERR_PORT with its data unchanged. The rest of its packet follows it to ERR_PORT, and err_flag is set and stays 1 until reset.
- R7: If a configuration write hits the entry that a head flit reads in the same cycle, that head flit uses the old contents. The next head flit uses the new contents.
- R8: A flit with both head and tail set is routed like a head flit and also closes the path.
- R9: err_flag is 1 in the same cycle that a misrouted flit appears at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming flit present |
| in_head | input | 1 | Incoming flit is a head flit |
| in_tail | input | 1 | Incoming flit is a tail flit |
| in_data | input | FLIT_W | Incoming flit payload; the index field is used for head flits |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | IDX_W | Table entry to write |
| cfg_port | input | PORT_W | Output port to store |
| cfg_next | input | IDX_W | Next index to store |
| cfg_ok | input | 1 | Entry-valid bit to store |
| out_valid | output | 1 | Outgoing flit present |
| out_head | output | 1 | Outgoing flit is a head flit |
| out_tail | output | 1 | Outgoing flit is a tail flit |
| out_data | output | FLIT_W | Outgoing payload, with the index field rewritten on head flits |
| out_port | output | PORT_W | Output port selected for this flit |
| err_flag | output | 1 | Sticky routing error |

## Verification
Every flit result, including head flits with their table lookup, is due exactly one cycle after the flit is presented. The bench drives inputs on the falling edge and compares the outputs on the next falling edge. A configuration write takes effect at the edge that samples it, so only a head flit presented on a later falling edge sees the new contents. The bench checks the same-cycle collision case on the head flit and then again on the following head flit. err_flag is compared in the same falling-edge window as the misrouted flit, and again after later flits to confirm that it stays set.

// File: rtl/route_idx_pkg.sv
package route_idx_pkg;
   localparam int DEF_FLIT_W  = 32;
   localparam int DEF_IDX_W   = 6;
   localparam int DEF_PORT_W  = 3;
   localparam int DEF_IDX_LSB = 0;

   typedef struct packed {
      logic valid;
      logic head;
      logic tail;
   } flit_ctl_t;
endpackage

// File: rtl/route_idx_table.sv
module route_idx_table #(
   parameter int IDX_W  = route_idx_pkg::DEF_IDX_W,
   parameter int PORT_W = route_idx_pkg::DEF_PORT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [IDX_W-1:0]  wr_next,
   input  logic              wr_ok,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [PORT_W-1:0] rd_port,
   output logic [IDX_W-1:0]  rd_next,
   output logic              rd_hit
);
   localparam int DEPTH = 1 << IDX_W;

   logic [PORT_W-1:0] port_mem [DEPTH];
   logic [IDX_W-1:0]  next_mem [DEPTH];
   logic [DEPTH-1:0]  ok_bits;

   // valid bits are the only reset state of the table
   for (genvar g = 0; g < DEPTH; g++) begin : g_ok
      always_ff @(posedge clk) begin
         if (rst)
            ok_bits[g] <= 1'b0;
         else if (wr_en && (wr_addr == IDX_W'(g)))
            ok_bits[g] <= wr_ok;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         port_mem[wr_addr] <= wr_port;
         next_mem[wr_addr] <= wr_next;
      end
   end

   // read samples the contents held before this edge's write
   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_port <= port_mem[rd_addr];
         rd_next <= next_mem[rd_addr];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_hit <= 1'b0;
      else if (rd_en)
         rd_hit <= ok_bits[rd_addr];
   end
endmodule

// File: rtl/route_idx_rewrite.sv
module route_idx_rewrite
   import route_idx_pkg::*;
#(
   parameter int FLIT_W   = DEF_FLIT_W,
   parameter int IDX_W    = DEF_IDX_W,
   parameter int PORT_W   = DEF_PORT_W,
   parameter int IDX_LSB  = DEF_IDX_LSB,
   parameter int ERR_PORT = (1 << DEF_PORT_W) - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_head,
   input  logic              in_tail,
   input  logic [FLIT_W-1:0] in_data,
   input  logic [PORT_W-1:0] rd_port,
   input  logic [IDX_W-1:0]  rd_next,
   input  logic              rd_hit,
   output logic              out_valid,
   output logic              out_head,
   output logic              out_tail,
   output logic [FLIT_W-1:0] out_data,
   output logic [PORT_W-1:0] out_port,
   output logic              err_flag
);
   localparam logic [PORT_W-1:0] ERR_P = PORT_W'(ERR_PORT);
   localparam int HI_LSB = IDX_LSB + IDX_W;

   flit_ctl_t         ctl_q;
   logic [FLIT_W-1:0] data_q;
   logic              path_open;
   logic [PORT_W-1:0] path_port;
   logic              err_q;
   logic              err_now;
   logic [PORT_W-1:0] sel_port;
   logic [FLIT_W-1:0] new_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
      end else begin
         ctl_q.valid <= in_valid;
         ctl_q.head  <= in_valid & in_head;
         ctl_q.tail  <= in_valid & in_tail;
      end
   end

   always_ff @(posedge clk) begin
      data_q <= in_data;
   end

   // index field position picks how the header is reassembled
   if (IDX_LSB == 0 && HI_LSB == FLIT_W) begin : g_whole
      assign new_data = FLIT_W'(rd_next);
   end else if (IDX_LSB == 0) begin : g_low
      assign new_data = {data_q[FLIT_W-1:HI_LSB], rd_next};
   end else if (HI_LSB == FLIT_W) begin : g_high
      assign new_data = {rd_next, data_q[IDX_LSB-1:0]};
   end else begin : g_mid
      assign new_data = {data_q[FLIT_W-1:HI_LSB], rd_next, data_q[IDX_LSB-1:0]};
   end

   always_comb begin
      if (ctl_q.head)
         sel_port = rd_hit ? rd_port : ERR_P;
      else
         sel_port = path_open ? path_port : ERR_P;
      err_now = ctl_q.valid & (ctl_q.head ? ~rd_hit : ~path_open);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         path_open <= 1'b0;
         path_port <= '0;
      end else if (ctl_q.valid) begin
         if (ctl_q.head) begin
            path_open <= ~ctl_q.tail;
            path_port <= sel_port;
         end else if (ctl_q.tail) begin
            path_open <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         err_q <= 1'b0;
      else if (err_now)
         err_q <= 1'b1;
   end

   assign out_valid = ctl_q.valid;
   assign out_head  = ctl_q.head;
   assign out_tail  = ctl_q.tail;
   assign out_port  = sel_port;
   assign out_data  = (ctl_q.head && rd_hit) ? new_data : data_q;
   assign err_flag  = err_q | err_now;
endmodule

// File: rtl/route_idx_stage.sv
module route_idx_stage
   import route_idx_pkg::*;
#(
   parameter int FLIT_W   = DEF_FLIT_W,
   parameter int IDX_W    = DEF_IDX_W,
   parameter int PORT_W   = DEF_PORT_W,
   parameter int IDX_LSB  = DEF_IDX_LSB,
   parameter int ERR_PORT = (1 << DEF_PORT_W) - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_head,
   input  logic              in_tail,
   input  logic [FLIT_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_addr,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic [IDX_W-1:0]  cfg_next,
   input  logic              cfg_ok,
   output logic              out_valid,
   output logic              out_head,
   output logic              out_tail,
   output logic [FLIT_W-1:0] out_data,
   output logic [PORT_W-1:0] out_port,
   output logic              err_flag
);
   if (IDX_LSB + IDX_W > FLIT_W) begin : g_bad_field
      $error("index field does not fit in the flit");
   end
   if (ERR_PORT >= (1 << PORT_W) || ERR_PORT < 0) begin : g_bad_err
      $error("error port outside port range");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("index width out of supported range");
   end

   logic [PORT_W-1:0] rd_port;
   logic [IDX_W-1:0]  rd_next;
   logic              rd_hit;
   logic              rd_en;

   assign rd_en = in_valid & in_head;

   route_idx_table #(.IDX_W(IDX_W), .PORT_W(PORT_W)) u_table (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_port (cfg_port),
      .wr_next (cfg_next),
      .wr_ok   (cfg_ok),
      .rd_en   (rd_en),
      .rd_addr (in_data[IDX_LSB +: IDX_W]),
      .rd_port (rd_port),
      .rd_next (rd_next),
      .rd_hit  (rd_hit)
   );

   route_idx_rewrite #(
      .FLIT_W(FLIT_W), .IDX_W(IDX_W), .PORT_W(PORT_W),
      .IDX_LSB(IDX_LSB), .ERR_PORT(ERR_PORT)
   ) u_rewrite (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_head   (in_head),
      .in_tail   (in_tail),
      .in_data   (in_data),
      .rd_port   (rd_port),
      .rd_next   (rd_next),
      .rd_hit    (rd_hit),
      .out_valid (out_valid),
      .out_head  (out_head),
      .out_tail  (out_tail),
      .out_data  (out_data),
      .out_port  (out_port),
      .err_flag  (err_flag)
   );
endmodule

// File: rtl/route_idx_chk.sv
module route_idx_chk #(
   parameter int FLIT_W   = 32,
   parameter int IDX_W    = 6,
   parameter int PORT_W   = 3,
   parameter int IDX_LSB  = 0,
   parameter int ERR_PORT = 7
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [FLIT_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_head,
   input logic [FLIT_W-1:0] out_data,
   input logic [PORT_W-1:0] out_port,
   input logic              err_flag
);
   localparam logic [FLIT_W-1:0] KEEP =
      ~(FLIT_W'({IDX_W{1'b1}}) << IDX_LSB);

   // R4
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   // R3
   body_data_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_head) |-> (out_data == $past(in_data)));

   // R2
   head_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_head) |-> ((out_data & KEEP) == ($past(in_data) & KEEP)));

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> err_flag);

   // R9
   err_port_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_port == PORT_W'(ERR_PORT)) |-> err_flag);
endmodule

bind route_idx_stage route_idx_chk #(
   .FLIT_W(FLIT_W), .IDX_W(IDX_W), .PORT_W(PORT_W),
   .IDX_LSB(IDX_LSB), .ERR_PORT(ERR_PORT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_head  (out_head),
   .out_data  (out_data),
   .out_port  (out_port),
   .err_flag  (err_flag)
);

// File: tb/test_route_idx_stage.sv
module test_route_idx_stage;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        iv;
      logic        ih;
      logic        it;
      logic [31:0] din;
      logic        ev;
      logic [2:0]  eport;
      logic [31:0] edata;
      logic        eerr;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,1'b0,32'hA5A5_0005, 1'b1,3'd2,32'hA5A5_0011,1'b0}, // R2 head idx5
      '{1'b1,1'b0,1'b0,32'h1234_5678, 1'b1,3'd2,32'h1234_5678,1'b0}, // R3 body
      '{1'b1,1'b0,1'b0,32'hFFFF_FFC0, 1'b1,3'd2,32'hFFFF_FFC0,1'b0}, // R3 body
      '{1'b1,1'b0,1'b1,32'h0BAD_F00D, 1'b1,3'd2,32'h0BAD_F00D,1'b0}, // R3 tail
      '{1'b1,1'b1,1'b1,32'h0000_0049, 1'b1,3'd4,32'h0000_007F,1'b0}, // R8 single
      '{1'b1,1'b1,1'b0,32'hC0DE_00FF, 1'b1,3'd0,32'hC0DE_00C5,1'b0}, // R2 idx63
      '{1'b1,1'b0,1'b0,32'h0000_0000, 1'b1,3'd0,32'h0000_0000,1'b0}, // R4 body
      '{1'b1,1'b0,1'b1,32'h0000_0001, 1'b1,3'd0,32'h0000_0001,1'b0}, // R3 tail
      '{1'b0,1'b0,1'b0,32'h0000_0000, 1'b0,3'd0,32'h0000_0000,1'b0}, // R4 idle
      '{1'b1,1'b0,1'b0,32'h0000_7777, 1'b1,3'd7,32'h0000_7777,1'b1}, // R5 orphan
      '{1'b1,1'b1,1'b0,32'hABCD_000C, 1'b1,3'd7,32'hABCD_000C,1'b1}, // R6 invalid
      '{1'b1,1'b0,1'b0,32'h0000_2222, 1'b1,3'd7,32'h0000_2222,1'b1}, // R6 body
      '{1'b1,1'b0,1'b1,32'h0000_0003, 1'b1,3'd7,32'h0000_0003,1'b1}  // R6 tail
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid, in_head, in_tail;
   logic [31:0] in_data;
   logic        cfg_we, cfg_ok;
   logic [5:0]  cfg_addr, cfg_next;
   logic [2:0]  cfg_port;
   logic        out_valid, out_head, out_tail, err_flag;
   logic [31:0] out_data;
   logic [2:0]  out_port;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   route_idx_stage i_route_idx_stage (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_port(cfg_port),
      .cfg_next(cfg_next), .cfg_ok(cfg_ok),
      .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail),
      .out_data(out_data), .out_port(out_port), .err_flag(err_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic h, input logic t, input logic [31:0] d);
      in_valid = v; in_head = h; in_tail = t; in_data = d;
   endtask

   task automatic cfg(input logic [5:0] a, input logic [2:0] p, input logic [5:0] n, input logic ok);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_port = p; cfg_next = n; cfg_ok = ok;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 32'h0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      cfg_we = 1'b0; cfg_addr = '0; cfg_port = '0; cfg_next = '0; cfg_ok = 1'b0;
      do_reset();
      @(negedge clk);
      chk("R1 out_valid", 32'(out_valid), 32'd0);
      chk("R1 err_flag", 32'(err_flag), 32'd0);

      cfg(6'd5,  3'd2, 6'd17, 1'b1);
      cfg(6'd9,  3'd4, 6'd63, 1'b1);
      cfg(6'd63, 3'd0, 6'd5,  1'b1);

      for (int k = 0; k <= NV; k++) begin
         @(negedge clk);
         if (k > 0) begin
            chk($sformatf("R4 valid v%0d", k-1), 32'(out_valid), 32'(VEC[k-1].ev));
            if (VEC[k-1].ev) begin
               chk($sformatf("R2/R3 port v%0d", k-1), 32'(out_port), 32'(VEC[k-1].eport));
               chk($sformatf("R2/R3 data v%0d", k-1), out_data, VEC[k-1].edata);
               chk($sformatf("R9 err v%0d", k-1), 32'(err_flag), 32'(VEC[k-1].eerr));
            end
         end
         if (k < NV)
            drive(VEC[k].iv, VEC[k].ih, VEC[k].it, VEC[k].din);
         else
            drive(1'b0, 1'b0, 1'b0, 32'h0);
      end

      // R7: rewrite entry 5 in the same cycle its head flit looks it up
      drive(1'b1, 1'b1, 1'b0, 32'h0000_0005);
      cfg_we = 1'b1; cfg_addr = 6'd5; cfg_port = 3'd3; cfg_next = 6'd40; cfg_ok = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R7 old port", 32'(out_port), 32'd2);
      chk("R7 old next", out_data, 32'h0000_0011);
      drive(1'b1, 1'b0, 1'b1, 32'h0000_0099);
      @(negedge clk);
      chk("R7 tail port", 32'(out_port), 32'd2);
      drive(1'b1, 1'b1, 1'b1, 32'h0000_0005);
      @(negedge clk);
      chk("R7 new port", 32'(out_port), 32'd3);
      chk("R7 new next", out_data, 32'h0000_0028);
      chk("R6 sticky err", 32'(err_flag), 32'd1);
      drive(1'b0, 1'b0, 1'b0, 32'h0);
      @(negedge clk);
      chk("R6 sticky idle", 32'(err_flag), 32'd1);

      // R1: reset clears error and invalidates the table
      do_reset();
      @(negedge clk);
      chk("R1 err cleared", 32'(err_flag), 32'd0);
      chk("R1 valid low", 32'(out_valid), 32'd0);
      drive(1'b1, 1'b1, 1'b1, 32'h0000_0005);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 32'h0);
      chk("R1 entry invalid port", 32'(out_port), 32'd7);
      chk("R1 entry invalid data", out_data, 32'h0000_0005);
      chk("R9 err on invalid", 32'(err_flag), 32'd1);

      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule